// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a family of derived clock outputs for power management. One master clock runs at twice the CPU output rate. From it the block builds a CPU-rate phase and a PCI-rate phase at half the CPU rate. Every output is a flop on the master clock, so no output can change between master edges.

The CPU group and most of the PCI group can be parked low on request. One PCI output never stops for a PCI stop request. The memory clock outputs run at the CPU rate and only a power-down silences them. A power-down request clears every output at once, including the free PCI clock and the reference copies. When the request is released, the block comes back on a clock edge with the dividers realigned.

The two stop requests share pads with the two highest memory clock outputs. A strap input decides which role those pads take. A stop request is active low at its pad. Each request is resynchronised in the domain of the group it gates. A group's enable changes only while that group's clock is low, so every high phase the block emits has full width.

Top module: `clkstop_ctrl`

## Requirements
- R1: While running, each CPU output toggles on every master clock edge, so its period is two master cycles. Each PCI output has a period of four master cycles. Every rising edge of a PCI output falls on a master edge where the CPU outputs also rise.
- R2: With `mode_i` = 1, all eight memory pads drive a CPU-rate clock with output enable 1, and the levels on `stop_pad_i` have no effect on any output.
- R3: With `mode_i` = 0, memory pads 6 and 7 have output enable 0 and drive 0. `stop_pad_i[0]` is the CPU stop request and `stop_pad_i[1]` is the PCI stop request, and a level of 0 requests a stop. Memory pads 0 to 5 keep running.
- R4: A CPU stop request holds all four CPU outputs low. It does not affect the PCI or memory outputs.
- R5: A PCI stop request holds the six gated PCI outputs low. `pci_free_o` keeps toggling, and the CPU outputs are unaffected.
- R6: Stop and restart happen only while the affected clock is low. Every CPU high phase lasts exactly one master cycle, and every PCI high phase lasts exactly two master cycles.
- R7: Each stop request passes through a two-stage synchroniser that advances only on its own group's rising edge. A CPU stop request takes effect, or is withdrawn, within 8 master cycles. A PCI stop request does so within 16 master cycles.
- R8: Asserting `pwr_down_i` drives every clock output low at once, without waiting for a clock edge. This covers the CPU, PCI, free PCI, memory and reference outputs, and they stay low while the request is held.
- R9: After `pwr_down_i` is released, the outputs restart within 8 master cycles, with the PCI rising edges aligned to the CPU rising edges.
- R10: While `rst_ni` is low, every clock output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock at twice the CPU output rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_down_i | input | 1 | Power-down request, asynchronous, active high |
| mode_i | input | 1 | Pad role strap: 0 = pads 6/7 are stop inputs, 1 = memory clocks |
| ref_i | input | 1 | Reference clock to be copied |
| stop_pad_i | input | 2 | Input levels of pads 6 (bit 0, CPU stop) and 7 (bit 1, PCI stop), active low |
| cpu_clk_o | output | NUM_CPU | CPU-group clocks |
| pci_clk_o | output | NUM_PCI | Gated PCI-group clocks |
| pci_free_o | output | 1 | PCI clock unaffected by PCI stop |
| mem_pad_o | output | NUM_MEM | Memory clock pad outputs |
| mem_pad_oe_o | output | NUM_MEM | Memory pad output enables |
| ref_o | output | NUM_REF | Reference clock copies, gated by power-down |

## Verification
Some properties are checked on every master cycle. These are that a group enable changes only on a cycle whose output is low, that no group output rises on the same edge its enable moves, and that a synchroniser only advances on its own group's tick. They also cover the PCI phase moving only alongside a CPU rising edge, and all outputs being silent while the power-down hold is active. Other behaviour only the bench scenarios can show. This includes the pad-role mux in both strap settings and the free PCI clock surviving a PCI stop. It also covers the latency bounds for stop and restart, the immediate effect of power-down between clock edges, and the realigned restart after power-down. A monitor measures every high phase of the CPU and PCI outputs across the whole run to catch runt pulses.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Role of the two shared memory pads, chosen by the strap input
    typedef enum logic {
        ROLE_STOP_IN = 1'b0,
        ROLE_MEM_CLK = 1'b1
    } pin_role_e;

    // Divider phases kept on the master clock
    typedef struct packed {
        logic cpu_ph;
        logic pci_ph;
        logic pci_free;
    } div_state_t;

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic tick_i,
    input  logic req_i,
    output logic req_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    // Shift only on the rising tick of the gated group's clock
    always_comb begin
        sync_d = sync_q;
        if (tick_i) begin
            sync_d = {sync_q[STAGES-2:0], req_i};
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign req_o = sync_q[STAGES-1];

    // R7
    sync_tick_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        !$stable(req_o) |-> $past(tick_i));

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             hold_i,
    input  logic             ph_next_i,
    input  logic             stop_i,
    output logic [WIDTH-1:0] clk_o
);

    typedef struct packed {
        logic             run;
        logic [WIDTH-1:0] out;
    } gate_state_t;

    gate_state_t st_d, st_q;

    // The enable may only move when the next phase is low
    always_comb begin
        st_d = st_q;
        if (!ph_next_i) begin
            st_d.run = !stop_i;
        end
        if (hold_i) begin
            st_d.run = 1'b1;
        end
        st_d.out = {WIDTH{ph_next_i && st_d.run && !hold_i}};
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) begin
            st_q.run <= 1'b1;
            st_q.out <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o = st_q.out;

    // R6
    park_low_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        !$stable(st_q.run) |-> (clk_o == '0));

    // R6
    full_high_chk: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(clk_o[0]) |-> $stable(st_q.run));

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
    parameter int NUM_CPU     = 4,
    parameter int NUM_PCI     = 6,
    parameter int NUM_MEM     = 8,
    parameter int NUM_REF     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pwr_down_i,
    input  logic               mode_i,
    input  logic               ref_i,
    input  logic [1:0]         stop_pad_i,
    output logic [NUM_CPU-1:0] cpu_clk_o,
    output logic [NUM_PCI-1:0] pci_clk_o,
    output logic               pci_free_o,
    output logic [NUM_MEM-1:0] mem_pad_o,
    output logic [NUM_MEM-1:0] mem_pad_oe_o,
    output logic [NUM_REF-1:0] ref_o
);
    import clkstop_pkg::*;

    localparam int CPU_STOP_PIN = NUM_MEM - 2;

    typedef struct packed {
        div_state_t         div;
        logic [1:0]         pd;
        logic [NUM_MEM-1:0] mem;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       arst;
    logic       hold;
    logic       cpu_tick, pci_tick;
    logic       cpu_req, pci_req;
    logic       cpu_stop, pci_stop;
    pin_role_e  role;

    assign arst = !rst_ni || pwr_down_i;
    assign hold = st_q.pd[1];
    assign role = pin_role_e'(mode_i);

    // Stop requests exist only when the shared pads are inputs
    assign cpu_req = (role == ROLE_STOP_IN) && !stop_pad_i[0];
    assign pci_req = (role == ROLE_STOP_IN) && !stop_pad_i[1];

    always_comb begin
        st_d    = st_q;
        st_d.pd = {st_q.pd[0], 1'b0};
        if (hold) begin
            st_d.div.cpu_ph = 1'b0;
            st_d.div.pci_ph = 1'b0;
        end else begin
            st_d.div.cpu_ph = !st_q.div.cpu_ph;
            st_d.div.pci_ph = st_q.div.pci_ph ^ !st_q.div.cpu_ph;
        end
        st_d.div.pci_free = st_d.div.pci_ph;
        st_d.mem          = {NUM_MEM{st_d.div.cpu_ph}};
    end

    // Power-down clears at once; release ripples through two flops
    always_ff @(posedge clk_i or posedge arst) begin
        if (arst) begin
            st_q.div <= '0;
            st_q.pd  <= 2'b11;
            st_q.mem <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_tick = st_d.div.cpu_ph && !st_q.div.cpu_ph;
    assign pci_tick = st_d.div.pci_ph && !st_q.div.pci_ph;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
        .clk_i  (clk_i),
        .arst_i (arst),
        .tick_i (cpu_tick),
        .req_i  (cpu_req),
        .req_o  (cpu_stop)
    );

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
        .clk_i  (clk_i),
        .arst_i (arst),
        .tick_i (pci_tick),
        .req_i  (pci_req),
        .req_o  (pci_stop)
    );

    clkstop_gate #(.WIDTH(NUM_CPU)) u_cpu_gate (
        .clk_i     (clk_i),
        .arst_i    (arst),
        .hold_i    (hold),
        .ph_next_i (st_d.div.cpu_ph),
        .stop_i    (cpu_stop),
        .clk_o     (cpu_clk_o)
    );

    clkstop_gate #(.WIDTH(NUM_PCI)) u_pci_gate (
        .clk_i     (clk_i),
        .arst_i    (arst),
        .hold_i    (hold),
        .ph_next_i (st_d.div.pci_ph),
        .stop_i    (pci_stop),
        .clk_o     (pci_clk_o)
    );

    assign pci_free_o = st_q.div.pci_free;

    // Pad role mux: the two top pads release their drivers as stop inputs
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_pad
        if (g >= CPU_STOP_PIN) begin : g_shared
            assign mem_pad_oe_o[g] = (role == ROLE_MEM_CLK);
            assign mem_pad_o[g]    = st_q.mem[g] && (role == ROLE_MEM_CLK);
        end else begin : g_plain
            assign mem_pad_oe_o[g] = 1'b1;
            assign mem_pad_o[g]    = st_q.mem[g];
        end
    end

    assign ref_o = {NUM_REF{ref_i && !hold}};

    // R8
    pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold |-> (cpu_clk_o == '0 && pci_clk_o == '0 && !pci_free_o && st_q.mem == '0));

    // R1
    pci_edge_chk: assert property (@(posedge clk_i) disable iff (arst)
        !$stable(st_q.div.pci_ph) |-> st_q.div.cpu_ph);

    // R1
    cpu_toggle_chk: assert property (@(posedge clk_i) disable iff (arst)
        !hold |=> (st_q.div.cpu_ph != $past(st_q.div.cpu_ph)));

endmodule

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_down;
    logic       mode;
    logic       ref_in;
    logic [1:0] stop_pad;
    logic [3:0] cpu_clk;
    logic [5:0] pci_clk;
    logic       pci_free;
    logic [7:0] mem_pad;
    logic [7:0] mem_oe;
    logic [1:0] ref_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clkstop_ctrl i_clkstop_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pwr_down_i   (pwr_down),
        .mode_i       (mode),
        .ref_i        (ref_in),
        .stop_pad_i   (stop_pad),
        .cpu_clk_o    (cpu_clk),
        .pci_clk_o    (pci_clk),
        .pci_free_o   (pci_free),
        .mem_pad_o    (mem_pad),
        .mem_pad_oe_o (mem_oe),
        .ref_o        (ref_out)
    );

    // Vector fields: [6] mode, [5] cpu stop pad, [4] pci stop pad,
    // expected [3] cpu runs, [2] pci runs, [1] pads 6/7 run, [0] pads 6/7 enabled
    localparam logic [6:0] VEC [8] = '{
        7'b1_11_1111,
        7'b1_00_1111,
        7'b0_11_1100,
        7'b0_01_0100,
        7'b0_10_1000,
        7'b0_00_0000,
        7'b0_11_1100,
        7'b1_00_1111
    };

    int cpu_rise, cpu_hi, cpu_split, pci_rise, pci_hi, pci_split;
    int free_rise, mem0_rise, mem67_rise, mem67_hi, align_err, oe_bad;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Counts transitions across n+1 samples taken at falling edges
    task automatic observe(input int n, input logic [1:0] exp_oe);
        logic pc, pp, pf, pm0, pm6;
        cpu_rise = 0; cpu_hi = 0; cpu_split = 0; pci_rise = 0; pci_hi = 0;
        pci_split = 0; free_rise = 0; mem0_rise = 0; mem67_rise = 0;
        mem67_hi = 0; align_err = 0; oe_bad = 0;
        @(negedge clk);
        pc = cpu_clk[0]; pp = pci_clk[0]; pf = pci_free; pm0 = mem_pad[0]; pm6 = mem_pad[6];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_clk[0] && !pc) cpu_rise++;
            if (|cpu_clk) cpu_hi++;
            if ((&cpu_clk) != (|cpu_clk)) cpu_split++;
            if (pci_clk[0] && !pp) pci_rise++;
            if (|pci_clk) pci_hi++;
            if ((&pci_clk) != (|pci_clk)) pci_split++;
            if (pci_free && !pf) begin
                free_rise++;
                if (!(cpu_clk[0] && !pc) && cpu_rise > 0) align_err++;
            end
            if (mem_pad[0] && !pm0) mem0_rise++;
            if (mem_pad[6] && !pm6) mem67_rise++;
            if (mem_pad[6] || mem_pad[7]) mem67_hi++;
            if (mem_oe[7:6] != exp_oe || mem_oe[5:0] != 6'h3f) oe_bad++;
            pc = cpu_clk[0]; pp = pci_clk[0]; pf = pci_free; pm0 = mem_pad[0]; pm6 = mem_pad[6];
        end
    endtask

    // R6 monitor: high phase widths of CPU and PCI outputs
    int cpu_len = 0, pci_len = 0, free_len = 0, runt = 0;
    always @(negedge clk) begin
        if (!rst_n || pwr_down) begin
            cpu_len = 0; pci_len = 0; free_len = 0;
        end else begin
            if (cpu_clk[0]) cpu_len++;
            else if (cpu_len != 0) begin if (cpu_len != 1) runt++; cpu_len = 0; end
            if (pci_clk[0]) pci_len++;
            else if (pci_len != 0) begin if (pci_len != 2) runt++; pci_len = 0; end
            if (pci_free) free_len++;
            else if (free_len != 0) begin if (free_len != 2) runt++; free_len = 0; end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_down = 1'b0; mode = 1'b1; ref_in = 1'b1; stop_pad = 2'b11;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk({cpu_clk, pci_clk, pci_free, mem_pad, ref_out} == '0, "R10", "outputs in reset",
            int'({cpu_clk, pci_clk, pci_free, mem_pad, ref_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1 rates and alignment
        observe(64, 2'b11);
        chk(cpu_rise == 32, "R1", "cpu rises", cpu_rise, 32);
        chk(free_rise == 16 && pci_rise == 16, "R1", "pci rises", pci_rise, 16);
        chk(align_err == 0, "R1", "pci/cpu edge alignment", align_err, 0);

        // Table of mode and stop combinations
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            mode = VEC[v][6];
            stop_pad = {VEC[v][4], VEC[v][5]};
            repeat (20) @(negedge clk);
            observe(32, {2{VEC[v][0]}});
            if (VEC[v][3]) chk(cpu_rise == 16 && cpu_split == 0, "R4", "cpu running", cpu_rise, 16);
            else           chk(cpu_hi == 0, "R4", "cpu parked", cpu_hi, 0);
            if (VEC[v][2]) chk(pci_rise == 8 && pci_split == 0, "R5", "pci running", pci_rise, 8);
            else           chk(pci_hi == 0, "R5", "pci parked", pci_hi, 0);
            chk(free_rise == 8, "R5", "free pci", free_rise, 8);
            chk(mem0_rise == 16, VEC[v][6] ? "R2" : "R3", "mem pad 0", mem0_rise, 16);
            if (VEC[v][1]) chk(mem67_rise == 16, "R2", "mem pads 6/7 running", mem67_rise, 16);
            else           chk(mem67_hi == 0, "R3", "mem pads 6/7 quiet", mem67_hi, 0);
            chk(oe_bad == 0, VEC[v][6] ? "R2" : "R3", "pad enables", oe_bad, 0);
        end

        // R7 latency bounds
        @(negedge clk); mode = 1'b0; stop_pad = 2'b11;
        repeat (20) @(negedge clk);
        stop_pad[0] = 1'b0;
        repeat (8) @(negedge clk);
        observe(8, 2'b00);
        chk(cpu_hi == 0, "R7", "cpu stop within 8", cpu_hi, 0);
        stop_pad[0] = 1'b1;
        repeat (8) @(negedge clk);
        observe(8, 2'b00);
        chk(cpu_rise == 4, "R7", "cpu restart within 8", cpu_rise, 4);
        stop_pad[1] = 1'b0;
        repeat (16) @(negedge clk);
        observe(16, 2'b00);
        chk(pci_hi == 0, "R7", "pci stop within 16", pci_hi, 0);
        stop_pad[1] = 1'b1;
        repeat (16) @(negedge clk);
        observe(16, 2'b00);
        chk(pci_rise == 4, "R7", "pci restart within 16", pci_rise, 4);

        // R8 asynchronous power-down
        @(negedge clk); mode = 1'b1;
        repeat (10) @(negedge clk);
        @(posedge clk); #1;
        pwr_down = 1'b1;
        #0.5;
        chk({cpu_clk, pci_clk, pci_free, mem_pad, ref_out} == '0, "R8", "immediate quiet",
            int'({cpu_clk, pci_clk, pci_free, mem_pad, ref_out}), 0);
        repeat (4) @(negedge clk);
        observe(16, 2'b11);
        chk(cpu_hi == 0 && pci_hi == 0 && free_rise == 0 && mem0_rise == 0 && mem67_hi == 0,
            "R8", "held quiet", cpu_hi + pci_hi + free_rise + mem0_rise + mem67_hi, 0);
        chk(ref_out == 2'b00, "R8", "reference gated", int'(ref_out), 0);

        // R9 release and realignment
        @(negedge clk); pwr_down = 1'b0;
        repeat (8) @(negedge clk);
        observe(32, 2'b11);
        chk(cpu_rise == 16 && free_rise == 8, "R9", "restart rates", cpu_rise, 16);
        chk(align_err == 0, "R9", "realigned edges", align_err, 0);
        chk(ref_out == 2'b11, "R9", "reference restored", int'(ref_out), 3);

        // R6 high phase widths over the whole run
        chk(runt == 0, "R6", "runt high phases", runt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule